// File: doc/BRIEF.md
# PLL Setting Search Engine

This block works out the multiplier and divider settings for a PLL, given a requested output frequency. A start strobe captures the parent frequency (in Hz, and again as a whole number of MHz) and the target frequency. The block then walks the candidate settings one per clock cycle. Each candidate is a multiplier code `m` (0..255), a pre-divide select `p` (0..1) and a power-of-two post-divide exponent `q` (0..7). It produces the candidate frequency `(parent_hz * (m+1)) >> (p+q)`. The division is a plain truncating shift, since the pre-divider is only ever 1 or 2.

The walk has a fixed order. `p` steps from 1 down to 0 in the outer loop, `q` from 7 down to 0 in the middle loop, and `m` from 0 up to 255 in the inner loop. Candidates above the target are discarded. The block keeps the one with the smallest shortfall and stops as soon as a shortfall of zero appears. When it finishes, it registers the chosen fields, a 3-bit loop-filter range code and the found frequency, and packs them into a 32-bit configuration word. It then raises a one-cycle done pulse. If every candidate overshoots, it raises an error instead and reports all-zero settings. Start and done are plain control pins with no handshake: a start seen while busy is dropped, and the results stay stable until the next search completes.

Top module: `pll_cfg_search`

## Requirements
- R1: After reset, busy, done and err are 0, and mul_o, div1_o, div2_o, filt_o, cfg_word and found_hz are all 0.
- R2: found_hz equals (parent_hz × (mul_o+1)) >> (div1_o+div2_o) with truncation. For parent 1000 Hz and target 3 Hz, the first candidate (m=0, p=1, q=7) yields 3 and is an exact hit.
- R3: One candidate is evaluated per cycle, in the nested order described above. If the start is sampled at edge E0, done is high after edge E(k+1), where k = ((1−p)·8 + (7−q))·256 + m for the candidate that ends the search. A full walk therefore takes 4096 cycles.
- R4: The first candidate whose value equals the target ends the search at once with that setting.
- R5: With no exact hit, the reported candidate is at or below the target and has the smallest shortfall. On a tie, the one met first in the walk order is kept.
- R6: If every candidate exceeds the target, err is 1 with done, and mul_o, div1_o, div2_o, filt_o, cfg_word and found_hz are all 0.
- R7: filt_o is computed from f = parent_mhz >> div1_o, for the chosen div1_o. It is 7 if f≥166, 6 if f≥104, 5 if f≥65, 4 if f≥42, 3 if f≥26, 2 if f≥16, 1 if f≥10, and 0 otherwise.
- R8: cfg_word holds filt_o zero-extended in bits 31:24, mul_o in bits 23:16, div1_o in bit 8 and div2_o in bits 2:0. All other bits are 0.
- R9: busy is high from the cycle after a start is accepted until done. A start while busy has no effect on the running search or its result.
- R10: done lasts exactly one cycle. All result outputs change only together with done, and they ignore input changes between searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (sampled when idle) |
| parent_hz | input | 32 | Parent frequency in Hz |
| parent_mhz | input | 8 | Parent frequency in whole MHz, used for the filter code |
| target_hz | input | 32 | Requested output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| err | output | 1 | No candidate at or below the target |
| mul_o | output | 8 | Chosen multiplier code m |
| div1_o | output | 1 | Chosen pre-divide select p |
| div2_o | output | 3 | Chosen post-divide exponent q |
| filt_o | output | 3 | Loop-filter range code |
| cfg_word | output | 32 | Packed configuration word |
| found_hz | output | 41 | Frequency of the chosen setting |

## Verification
The hardest case to reach from the ports is a tie. Two candidates must fall short of the target by the same nonzero amount, and the earlier one must be kept. Parent 1 MHz with target 1 000 001 Hz makes several settings produce exactly 1 MHz, and none hits the target. The stimulus checks that the first of them, met at the very end of the first sweep, is reported. Exact hits at known walk positions and a start that arrives mid-search pin down the cycle count and the busy rule.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int FILT_LVLS = 7;
  localparam int FILT_W    = $clog2(FILT_LVLS + 1);

  typedef enum logic {S_IDLE, S_RUN} srch_st_e;

  // Ascending MHz thresholds; the code is the count of thresholds met.
  function automatic logic [7:0] filt_thr(input int idx);
    case (idx)
      0: filt_thr = 8'd10;
      1: filt_thr = 8'd16;
      2: filt_thr = 8'd26;
      3: filt_thr = 8'd42;
      4: filt_thr = 8'd65;
      5: filt_thr = 8'd104;
      default: filt_thr = 8'd166;
    endcase
  endfunction
endpackage

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int PAR_W = 32,
  parameter int MUL_W = 8,
  parameter int D2_W  = 3,
  localparam int PROD_W = PAR_W + MUL_W + 1
) (
  input  logic [PAR_W-1:0]  par,
  input  logic [PAR_W-1:0]  tgt,
  input  logic [MUL_W-1:0]  mul,
  input  logic              d1,
  input  logic [D2_W-1:0]   d2,
  output logic [PROD_W-1:0] cand,
  output logic              fits,
  output logic [PROD_W-1:0] gap
);
  logic [MUL_W:0]    mul_p1;
  logic [PROD_W-1:0] prod;
  logic [D2_W:0]     sh;

  always_comb begin
    mul_p1 = {1'b0, mul} + 1'b1;
    prod   = PROD_W'(par) * PROD_W'(mul_p1);
    sh     = (D2_W+1)'(d2) + (D2_W+1)'(d1);
    cand   = prod >> sh;
    fits   = cand <= PROD_W'(tgt);
    gap    = PROD_W'(tgt) - cand;
  end
endmodule

// File: rtl/pll_filter_map.sv
module pll_filter_map
  import pll_search_pkg::*;
#(
  parameter int MHZ_W = 8
) (
  input  logic [MHZ_W-1:0]  mhz,
  input  logic              d1,
  output logic [FILT_W-1:0] code
);
  logic [MHZ_W-1:0]     f_in;
  logic [FILT_LVLS-1:0] ge;

  assign f_in = mhz >> d1;

  for (genvar i = 0; i < FILT_LVLS; i++) begin : g_lvl
    assign ge[i] = f_in >= MHZ_W'(filt_thr(i));
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < FILT_LVLS; i++) code = code + FILT_W'(ge[i]);
  end
endmodule

// File: rtl/pll_search_ctrl.sv
module pll_search_ctrl
  import pll_search_pkg::*;
#(
  parameter int PAR_W = 32,
  parameter int MHZ_W = 8,
  parameter int MUL_W = 8,
  parameter int D2_W  = 3,
  localparam int PROD_W = PAR_W + MUL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAR_W-1:0]  parent_hz,
  input  logic [MHZ_W-1:0]  parent_mhz,
  input  logic [PAR_W-1:0]  target_hz,
  // candidate evaluator
  output logic [PAR_W-1:0]  par_q,
  output logic [PAR_W-1:0]  tgt_q,
  output logic [MUL_W-1:0]  m_q,
  output logic              d1_q,
  output logic [D2_W-1:0]   d2_q,
  input  logic [PROD_W-1:0] cand,
  input  logic              fits,
  input  logic [PROD_W-1:0] gap,
  // filter map
  output logic [MHZ_W-1:0]  mhz_q,
  output logic              sel_d1,
  input  logic [FILT_W-1:0] code,
  // results
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [MUL_W-1:0]  mul_o,
  output logic              d1_o,
  output logic [D2_W-1:0]   d2_o,
  output logic [FILT_W-1:0] filt_o,
  output logic [PROD_W-1:0] found_o
);
  srch_st_e          st_q;
  logic [MUL_W-1:0]  bm_q;
  logic              bd1_q;
  logic [D2_W-1:0]   bd2_q;
  logic [PROD_W-1:0] bf_q, be_q;
  logic              have_q;
  logic              hit, better, last, take_cur, ok;

  always_comb begin
    hit      = fits && (gap == '0);
    better   = fits && (!have_q || gap < be_q);
    last     = (d1_q == 1'b0) && (d2_q == '0) && (m_q == '1);
    take_cur = hit || better;
    ok       = take_cur || have_q;
    sel_d1   = take_cur ? d1_q : bd1_q;
  end

  assign busy_o = (st_q == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      par_q <= '0; tgt_q <= '0; mhz_q <= '0;
      m_q <= '0; d1_q <= 1'b1; d2_q <= '1;
      bm_q <= '0; bd1_q <= 1'b0; bd2_q <= '0; bf_q <= '0; be_q <= '0;
      have_q <= 1'b0;
      done_o <= 1'b0; err_o <= 1'b0;
      mul_o <= '0; d1_o <= 1'b0; d2_o <= '0; filt_o <= '0; found_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (st_q == S_IDLE) begin
        if (start) begin
          st_q  <= S_RUN;
          par_q <= parent_hz; tgt_q <= target_hz; mhz_q <= parent_mhz;
          m_q <= '0; d1_q <= 1'b1; d2_q <= '1;
          have_q <= 1'b0;
        end
      end else if (hit || last) begin
        st_q   <= S_IDLE;
        done_o <= 1'b1;
        err_o  <= !ok;
        if (!ok) begin
          mul_o <= '0; d1_o <= 1'b0; d2_o <= '0; filt_o <= '0; found_o <= '0;
        end else if (take_cur) begin
          mul_o <= m_q; d1_o <= d1_q; d2_o <= d2_q; filt_o <= code; found_o <= cand;
        end else begin
          mul_o <= bm_q; d1_o <= bd1_q; d2_o <= bd2_q; filt_o <= code; found_o <= bf_q;
        end
      end else begin
        if (better) begin
          bm_q <= m_q; bd1_q <= d1_q; bd2_q <= d2_q; bf_q <= cand; be_q <= gap;
          have_q <= 1'b1;
        end
        m_q <= m_q + 1'b1;
        if (m_q == '1) begin
          if (d2_q == '0) begin
            d2_q <= '1;
            d1_q <= 1'b0;
          end else begin
            d2_q <= d2_q - 1'b1;
          end
        end
      end
    end
  end

  // R10: done is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R3: completion returns the engine to idle
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R9: a start during a search leaves the captured operands alone
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start) |=> ($stable(tgt_q) && $stable(par_q)));
  // R5: a reported setting never overshoots
  p_found_le_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (found_o <= PROD_W'(tgt_q)));
endmodule

// File: rtl/pll_cfg_search.sv
module pll_cfg_search
  import pll_search_pkg::*;
#(
  parameter int PAR_W = 32,
  parameter int MHZ_W = 8,
  parameter int MUL_W = 8,
  parameter int D2_W  = 3,
  localparam int PROD_W = PAR_W + MUL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAR_W-1:0]  parent_hz,
  input  logic [MHZ_W-1:0]  parent_mhz,
  input  logic [PAR_W-1:0]  target_hz,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [MUL_W-1:0]  mul_o,
  output logic              div1_o,
  output logic [D2_W-1:0]   div2_o,
  output logic [FILT_W-1:0] filt_o,
  output logic [31:0]       cfg_word,
  output logic [PROD_W-1:0] found_hz
);
  logic [PAR_W-1:0]  par_q, tgt_q;
  logic [MUL_W-1:0]  m_q;
  logic              d1_q, sel_d1, fits;
  logic [D2_W-1:0]   d2_q;
  logic [PROD_W-1:0] cand, gap;
  logic [MHZ_W-1:0]  mhz_q;
  logic [FILT_W-1:0] code;

  pll_cand_eval #(.PAR_W(PAR_W), .MUL_W(MUL_W), .D2_W(D2_W)) u_eval (
    .par(par_q), .tgt(tgt_q), .mul(m_q), .d1(d1_q), .d2(d2_q),
    .cand(cand), .fits(fits), .gap(gap));

  pll_filter_map #(.MHZ_W(MHZ_W)) u_filt (
    .mhz(mhz_q), .d1(sel_d1), .code(code));

  pll_search_ctrl #(.PAR_W(PAR_W), .MHZ_W(MHZ_W), .MUL_W(MUL_W), .D2_W(D2_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .parent_hz(parent_hz), .parent_mhz(parent_mhz), .target_hz(target_hz),
    .par_q(par_q), .tgt_q(tgt_q), .m_q(m_q), .d1_q(d1_q), .d2_q(d2_q),
    .cand(cand), .fits(fits), .gap(gap),
    .mhz_q(mhz_q), .sel_d1(sel_d1), .code(code),
    .busy_o(busy), .done_o(done), .err_o(err),
    .mul_o(mul_o), .d1_o(div1_o), .d2_o(div2_o), .filt_o(filt_o), .found_o(found_hz));

  // Field positions are fixed by the consumer of the word.
  always_comb begin
    cfg_word        = '0;
    cfg_word[31:24] = 8'(filt_o);
    cfg_word[23:16] = 8'(mul_o);
    cfg_word[8]     = div1_o;
    cfg_word[2:0]   = 3'(div2_o);
  end

  // R10: the word only moves together with done
  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cfg_word) && $stable(found_hz)));
  // R6: an error carries no setting
  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (cfg_word == 32'd0 && found_hz == '0));
endmodule

// File: tb/sim_pll_cfg_search.sv
module sim_pll_cfg_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parent_hz = '0;
  logic [7:0]  parent_mhz = '0;
  logic [31:0] target_hz = '0;
  logic        busy, done, err, div1_o;
  logic [7:0]  mul_o;
  logic [2:0]  div2_o, filt_o;
  logic [31:0] cfg_word;
  logic [40:0] found_hz;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  pll_cfg_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .parent_hz(parent_hz),
    .parent_mhz(parent_mhz), .target_hz(target_hz), .busy(busy), .done(done),
    .err(err), .mul_o(mul_o), .div1_o(div1_o), .div2_o(div2_o), .filt_o(filt_o),
    .cfg_word(cfg_word), .found_hz(found_hz));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Starts a search and waits for done; cyc holds edges after the start edge.
  task automatic launch(input logic [31:0] ph, input logic [7:0] pm, input logic [31:0] th);
    @(negedge clk);
    parent_hz = ph; parent_mhz = pm; target_hz = th; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) return;
    end
    chk(1'b0, "watchdog", cyc, 4096);
  endtask

  task automatic expect_set(input string tag, input int m, input int p, input int q,
                            input longint f, input int code, input int cycles);
    eq({tag, " R2 mul"}, mul_o, m);
    eq({tag, " R2 div1"}, div1_o, p);
    eq({tag, " R2 div2"}, div2_o, q);
    eq({tag, " R2 found"}, found_hz, f);
    eq({tag, " R7 filt"}, filt_o, code);
    eq({tag, " R8 word"}, cfg_word, (code << 24) | (m << 16) | (p << 8) | q);
    eq({tag, " R3 cycles"}, cyc, cycles);
    eq({tag, " R6 err"}, err, 0);
  endtask

  function automatic int walk_pos(input int m, input int p, input int q);
    return ((1 - p) * 8 + (7 - q)) * 256 + m + 1;
  endfunction

  task automatic t_reset;
    eq("R1 busy", busy, 0); eq("R1 done", done, 0); eq("R1 err", err, 0);
    eq("R1 word", cfg_word, 0); eq("R1 found", found_hz, 0); eq("R1 filt", filt_o, 0);
  endtask

  task automatic t_exact_early;  // R4: 25e6*4>>8 = 390625 at walk position 4
    launch(32'd25_000_000, 8'd25, 32'd390_625);
    wait_done;
    expect_set("R4 exact", 3, 1, 7, 390_625, 1, walk_pos(3, 1, 7));
    @(negedge clk);
    eq("R10 done pulse", done, 0);
  endtask

  task automatic t_truncate;  // R2: 1000/256 truncates to 3; f=200>>1=100 -> code 5
    launch(32'd1000, 8'd200, 32'd3);
    wait_done;
    expect_set("R2 trunc", 0, 1, 7, 3, 5, 1);
  endtask

  task automatic t_ceiling;  // R5: only the last candidate reaches 256e6
    launch(32'd1_000_000, 8'd1, 32'd300_000_000);
    wait_done;
    expect_set("R5 best", 255, 0, 0, 256_000_000, 0, 4096);
  endtask

  task automatic t_tie;  // R5: first 1e6 reached is m=255,p=1,q=7
    launch(32'd1_000_000, 8'd1, 32'd1_000_001);
    wait_done;
    expect_set("R5 tie", 255, 1, 7, 1_000_000, 0, 4096);
  endtask

  task automatic t_error;  // R6: smallest candidate 97656 exceeds 50000
    launch(32'd25_000_000, 8'd25, 32'd50_000);
    wait_done;
    eq("R6 err", err, 1); eq("R6 word", cfg_word, 0); eq("R6 found", found_hz, 0);
    eq("R6 mul", mul_o, 0); eq("R6 filt", filt_o, 0); eq("R3 full walk", cyc, 4096);
  endtask

  task automatic t_filter;  // R7: parent 1 Hz, target 256 hits only at p=0
    int mh[10] = '{166, 165, 104, 103, 65, 42, 26, 16, 10, 9};
    int cd[10] = '{7, 6, 6, 5, 5, 4, 3, 2, 1, 0};
    for (int i = 0; i < 10; i++) begin
      launch(32'd1, 8'(mh[i]), 32'd256);
      wait_done;
      eq($sformatf("R7 filt mhz=%0d", mh[i]), filt_o, cd[i]);
      eq("R8 word filt field", cfg_word[31:24], cd[i]);
    end
  endtask

  task automatic t_busy_start;  // R9, R10
    launch(32'd1_000_000, 8'd1, 32'd300_000_000);
    repeat (100) @(negedge clk);
    eq("R9 busy mid", busy, 1);
    parent_hz = 32'd25_000_000; parent_mhz = 8'd25; target_hz = 32'd390_625; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 101;
    wait_done;
    expect_set("R9 ignored", 255, 0, 0, 256_000_000, 0, 4096);
    parent_hz = 32'd7; target_hz = 32'd9; parent_mhz = 8'd200;
    repeat (5) @(negedge clk);
    eq("R10 hold word", cfg_word, 32'h00FF_0000);
    eq("R10 hold found", found_hz, 256_000_000);
    eq("R9 idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_exact_early;
    t_truncate;
    t_ceiling;
    t_tie;
    t_error;
    t_filter;
    t_busy_start;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150_000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule